// File: doc/BRIEF.md
# ROM Patch Address Matcher

This block decides whether a fetch falls inside a region of ROM that is to be replaced by patch data. It holds a small set of correction channels. Each channel has an enable bit and a 20-bit base address, and covers an eight-byte window that starts at that base. On every fetch the block compares the low 20 bits of the fetch address with every enabled channel. In the same cycle it reports a hit, the index of the winning channel and the byte offset of the fetch inside that window. The logic that then supplies the patch bytes to the core sits outside this block.

The channel registers are written over a simple 32-bit word register port. A guard holds them against stray writes. It is a two-state machine, `GUARD_LOCKED` and `GUARD_OPEN`. The transition *open* (`GUARD_LOCKED` to `GUARD_OPEN`) happens when the control word is written with bit 0 set. The transition *close* (`GUARD_OPEN` to `GUARD_LOCKED`) happens when the control word is written with bit 0 clear. Any other write leaves the state unchanged. The guard leaves reset in `GUARD_LOCKED`. Channel registers accept writes only in `GUARD_OPEN`.

Top module: `rom_patch_matcher`

## Requirements
- R1: The control word sits at register offset 0x00. Bit 0 is the unlock flag, which resets to 0 and can be written at any time. Reading the control word returns the flag in bit 0 and 0 in bits 31:1.
- R2: Channel 0's word sits at offset 0x10 and channel 1's word at offset 0x20. In a channel word, bit 31 is the enable and bits 19:0 are the base address. Bits 30:20 always read as 0, whatever value was written.
- R3: After reset every channel enable reads 0, and no fetch produces a hit.
- R4: A write to a channel word while the unlock flag is 0 changes neither its enable nor its base.
- R5: `hit` is 1 when `fetch_valid` is 1 and some enabled channel satisfies base <= fetch_addr[19:0] <= base+7. Bits 31:20 of the fetch address play no part, and a disabled channel never hits.
- R6: Windows do not wrap. A base of 0xFFFFC covers 0xFFFFC..0xFFFFF only, and a fetch of 0x00000..0x00003 does not hit it.
- R7: On a hit, `hit_chan` gives the channel index and `hit_offset` gives fetch_addr[19:0] minus that channel's base (0..7).
- R8: When several channels hit on the same fetch, the lowest channel index wins.
- R9: With `fetch_valid` low, `hit` is 0. Whenever `hit` is 0, `hit_chan` and `hit_offset` are 0.
- R10: Offsets other than the control word and the channel words read as 0. Writes to them change no register.
- R11: The hit outputs are combinational. They reflect the fetch address presented in the same cycle, with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| fetch_valid | input | 1 | Fetch strobe |
| fetch_addr | input | 32 | Fetch address |
| hit | output | 1 | Fetch falls in an enabled channel window |
| hit_chan | output | 1 | Index of the winning channel |
| hit_offset | output | 3 | Byte offset of the fetch within the window |

## Verification
The hardest case to reach is two enabled windows that overlap, because only an overlap can show whether the lower index really wins. The stimulus opens the guard and places channel 1 four bytes above channel 0. It then probes the shared bytes and the bytes that only one channel covers. It also moves channel 1 to the top of the 20-bit space and fetches just below and just past zero, to show that no window wraps. Finally it closes the guard and attempts writes, checking the locked contents through readback and fetches.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

    typedef enum logic [0:0] {
        GUARD_LOCKED = 1'b0,
        GUARD_OPEN   = 1'b1
    } guard_state_e;

endpackage

// File: rtl/rpm_guard_fsm.sv
module rpm_guard_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic unlock_req,
    output logic wr_allow,
    output logic unlock_bit
);
    import rpm_pkg::*;

    guard_state_e state_q;
    guard_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_LOCKED: if (ctrl_wr && unlock_req)  state_d = GUARD_OPEN;
            GUARD_OPEN:   if (ctrl_wr && !unlock_req) state_d = GUARD_LOCKED;
            default:      state_d = GUARD_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GUARD_LOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_allow   = 1'b0;
        unlock_bit = 1'b0;
        unique case (state_q)
            GUARD_OPEN: begin
                wr_allow   = 1'b1;
                unlock_bit = 1'b1;
            end
            default: begin
                wr_allow   = 1'b0;
                unlock_bit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rpm_channel.sv
module rpm_channel #(
    parameter int ADDR_W   = 20,
    parameter int WIN_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_sel,
    input  logic                en_in,
    input  logic [ADDR_W-1:0]   base_in,
    input  logic [ADDR_W-1:0]   fetch_lo,
    output logic                en_q,
    output logic [ADDR_W-1:0]   base_q,
    output logic                in_win,
    output logic [WIN_LOG2-1:0] offset
);
    logic [ADDR_W:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
        end else if (wr_sel) begin
            en_q   <= en_in;
            base_q <= base_in;
        end
    end

    // extra top bit catches a borrow, so a window never wraps past zero
    always_comb begin
        diff   = {1'b0, fetch_lo} - {1'b0, base_q};
        in_win = en_q && !diff[ADDR_W] && (diff[ADDR_W-1:WIN_LOG2] == '0);
        offset = diff[WIN_LOG2-1:0];
    end

endmodule

// File: rtl/rpm_hit_select.sv
module rpm_hit_select #(
    parameter int NUM_CH   = 2,
    parameter int WIN_LOG2 = 3,
    parameter int IDX_W    = 1
) (
    input  logic                              fetch_valid,
    input  logic [NUM_CH-1:0]                 in_win,
    input  logic [NUM_CH-1:0][WIN_LOG2-1:0]   offs,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx,
    output logic [WIN_LOG2-1:0]               off
);
    // scan downward so the lowest index is assigned last and wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        off = '0;
        if (fetch_valid) begin
            for (int i = NUM_CH - 1; i >= 0; i--) begin
                if (in_win[i]) begin
                    hit = 1'b1;
                    idx = IDX_W'(i);
                    off = offs[i];
                end
            end
        end
    end

endmodule

// File: rtl/rom_patch_matcher.sv
module rom_patch_matcher #(
    parameter int NUM_CH      = 2,
    parameter int ADDR_W      = 20,
    parameter int WIN_LOG2    = 3,
    parameter int DATA_W      = 32,
    parameter int FETCH_W     = 32,
    parameter int REG_AW      = 8,
    parameter int CTRL_OFF    = 'h00,
    parameter int CH_BASE_OFF = 'h10,
    parameter int REG_STRIDE  = 'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                fetch_valid,
    input  logic [FETCH_W-1:0]  fetch_addr,
    output logic                hit,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] hit_chan,
    output logic [WIN_LOG2-1:0] hit_offset
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int RSV_W = DATA_W - 1 - ADDR_W;
    localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(CTRL_OFF);

    logic                             ctrl_wr;
    logic                             wr_allow;
    logic                             unlock_bit;
    logic [NUM_CH-1:0]                ch_wr;
    logic [NUM_CH-1:0]                ch_en_q;
    logic [NUM_CH-1:0][ADDR_W-1:0]    ch_base_q;
    logic [NUM_CH-1:0]                ch_in_win;
    logic [NUM_CH-1:0][WIN_LOG2-1:0]  ch_off;
    logic [ADDR_W-1:0]                fetch_lo;
    logic                             unused_bits;

    assign fetch_lo    = fetch_addr[ADDR_W-1:0];
    assign unused_bits = ^{fetch_addr[FETCH_W-1:ADDR_W], reg_wdata[DATA_W-2:ADDR_W]};
    assign ctrl_wr     = reg_wr && (reg_addr == CTRL_A);

    rpm_guard_fsm guard_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .unlock_req (reg_wdata[0]),
        .wr_allow   (wr_allow),
        .unlock_bit (unlock_bit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [REG_AW-1:0] OFF_G = REG_AW'(CH_BASE_OFF + g * REG_STRIDE);

        assign ch_wr[g] = reg_wr && wr_allow && (reg_addr == OFF_G);

        rpm_channel #(
            .ADDR_W   (ADDR_W),
            .WIN_LOG2 (WIN_LOG2)
        ) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (ch_wr[g]),
            .en_in    (reg_wdata[DATA_W-1]),
            .base_in  (reg_wdata[ADDR_W-1:0]),
            .fetch_lo (fetch_lo),
            .en_q     (ch_en_q[g]),
            .base_q   (ch_base_q[g]),
            .in_win   (ch_in_win[g]),
            .offset   (ch_off[g])
        );
    end

    rpm_hit_select #(
        .NUM_CH   (NUM_CH),
        .WIN_LOG2 (WIN_LOG2),
        .IDX_W    (IDX_W)
    ) sel_i (
        .fetch_valid (fetch_valid),
        .in_win      (ch_in_win),
        .offs        (ch_off),
        .hit         (hit),
        .idx         (hit_chan),
        .off         (hit_offset)
    );

    // read mux: reserved bits and unmapped offsets return zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_A) reg_rdata[0] = unlock_bit;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == REG_AW'(CH_BASE_OFF + i * REG_STRIDE))
                reg_rdata = {ch_en_q[i], {RSV_W{1'b0}}, ch_base_q[i]};
        end
    end

endmodule

// File: rtl/rpm_checker.sv
module rpm_checker #(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 20,
    parameter int WIN_LOG2 = 3,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           fetch_valid,
    input logic [ADDR_W-1:0]              fetch_lo,
    input logic                           hit,
    input logic [IDX_W-1:0]               hit_chan,
    input logic [WIN_LOG2-1:0]            hit_offset,
    input logic [DATA_W-1:0]              reg_rdata,
    input logic                           unlock,
    input logic [NUM_CH-1:0]              ch_en,
    input logic [NUM_CH-1:0][ADDR_W-1:0]  ch_base
);
    logic [ADDR_W:0] d0;
    logic            ch0_cover;

    always_comb begin
        d0        = {1'b0, fetch_lo} - {1'b0, ch_base[0]};
        ch0_cover = ch_en[0] && (d0[ADDR_W:WIN_LOG2] == '0);
    end

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !hit);                                             // R9
    AST_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_chan == '0 && hit_offset == '0));                     // R9
    AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ch_en[hit_chan]);                                           // R5
    AST_OFFSET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (fetch_lo == ch_base[hit_chan] + ADDR_W'(hit_offset)));     // R7
    AST_LOW_INDEX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_chan != '0) |-> !ch0_cover);                            // R8
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> ($stable(ch_en) && $stable(ch_base)));                  // R4
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-2:ADDR_W] == '0);                                  // R2

endmodule

bind rom_patch_matcher rpm_checker #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_lo    (fetch_addr[ADDR_W-1:0]),
    .hit         (hit),
    .hit_chan    (hit_chan),
    .hit_offset  (hit_offset),
    .reg_rdata   (reg_rdata),
    .unlock      (unlock_bit),
    .ch_en       (ch_en_q),
    .ch_base     (ch_base_q)
);

// File: tb/rom_patch_matcher_tb_top.sv
module rom_patch_matcher_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        hit;
    logic        hit_chan;
    logic [2:0]  hit_offset;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  e_hit;
        logic  e_chan;
        logic [2:0] e_off;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rom_patch_matcher dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .hit         (hit),
        .hit_chan    (hit_chan),
        .hit_offset  (hit_offset)
    );

    // monitor: outputs are combinational, so results are compared in the drive cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (hit !== e.e_hit || hit_chan !== e.e_chan || hit_offset !== e.e_off) begin
                    n_bad++;
                    $display("FAIL %s actual hit=%0b chan=%0d off=%0d expected hit=%0b chan=%0d off=%0d",
                             e.tag, hit, hit_chan, hit_offset, e.e_hit, e.e_chan, e.e_off);
                end
            end
        end
    end

    task automatic drive_fetch(input logic v, input logic [31:0] a, input logic eh,
                               input logic ec, input logic [2:0] eo, input string tag);
        exp_t e;
        @(posedge clk); #1;
        fetch_valid = v;
        fetch_addr  = a;
        e.e_hit = eh; e.e_chan = ec; e.e_off = eo; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic check_read(input logic [7:0] a, input logic [31:0] mask,
                              input logic [31:0] exp, input string tag);
        logic [31:0] d;
        reg_read(a, d);
        n_cmp++;
        if ((d & mask) !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, d & mask, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] before_w;
        logic [31:0] after_w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        check_read(8'h00, 32'hFFFF_FFFF, 32'h0, "R1 control after reset");
        check_read(8'h10, 32'hFFF0_0000, 32'h0, "R3 ch0 enable after reset");
        check_read(8'h20, 32'hFFF0_0000, 32'h0, "R3 ch1 enable after reset");
        drive_fetch(1'b1, 32'h0000_0000, 1'b0, 1'b0, 3'd0, "R3 no hit after reset");

        // locked write is dropped
        reg_read(8'h10, before_w);
        reg_write(8'h10, 32'h8000_1000);
        reg_read(8'h10, after_w);
        n_cmp++;
        if (after_w !== before_w) begin
            n_bad++;
            $display("FAIL R4 locked write actual=0x%08h expected=0x%08h", after_w, before_w);
        end
        drive_fetch(1'b1, 32'h0000_1000, 1'b0, 1'b0, 3'd0, "R4 locked channel stays off");

        // open guard and program channel 0
        reg_write(8'h00, 32'h0000_0001);
        check_read(8'h00, 32'hFFFF_FFFF, 32'h1, "R1 unlock readback");
        reg_write(8'h10, 32'hFFF0_1000);
        check_read(8'h10, 32'hFFFF_FFFF, 32'h8000_1000, "R2 reserved bits read zero");

        drive_fetch(1'b1, 32'h0000_1000, 1'b1, 1'b0, 3'd0, "R5 window start");
        drive_fetch(1'b1, 32'h0000_1007, 1'b1, 1'b0, 3'd7, "R5 window end");
        drive_fetch(1'b1, 32'h0000_0FFF, 1'b0, 1'b0, 3'd0, "R5 below window");
        drive_fetch(1'b1, 32'h0000_1008, 1'b0, 1'b0, 3'd0, "R5 above window");
        drive_fetch(1'b1, 32'hABC0_1003, 1'b1, 1'b0, 3'd3, "R5 upper bits ignored");
        drive_fetch(1'b0, 32'h0000_1002, 1'b0, 1'b0, 3'd0, "R9 strobe low");

        // overlap: channel 1 four bytes above channel 0
        reg_write(8'h20, 32'h8000_1004);
        drive_fetch(1'b1, 32'h0000_1005, 1'b1, 1'b0, 3'd5, "R8 overlap lowest wins");
        drive_fetch(1'b1, 32'h0000_1009, 1'b1, 1'b1, 3'd5, "R7 ch1 offset");
        drive_fetch(1'b1, 32'h0000_100B, 1'b1, 1'b1, 3'd7, "R7 ch1 last byte");
        drive_fetch(1'b1, 32'h0000_100C, 1'b0, 1'b0, 3'd0, "R5 past ch1");
        drive_fetch(1'b1, 32'h0000_1003, 1'b1, 1'b0, 3'd3, "R11 back-to-back change");

        // top of address space, no wrap
        reg_write(8'h20, 32'h800F_FFFC);
        drive_fetch(1'b1, 32'h000F_FFFF, 1'b1, 1'b1, 3'd3, "R6 top byte");
        drive_fetch(1'b1, 32'h0000_0000, 1'b0, 1'b0, 3'd0, "R6 no wrap zero");
        drive_fetch(1'b1, 32'h0000_0002, 1'b0, 1'b0, 3'd0, "R6 no wrap two");

        // disable channel 0
        reg_write(8'h10, 32'h0000_1000);
        drive_fetch(1'b1, 32'h0000_1000, 1'b0, 1'b0, 3'd0, "R5 disabled channel");

        // unmapped offsets
        reg_write(8'h30, 32'h8000_2000);
        check_read(8'h30, 32'hFFFF_FFFF, 32'h0, "R10 unmapped 0x30 reads zero");
        check_read(8'h14, 32'hFFFF_FFFF, 32'h0, "R10 unmapped 0x14 reads zero");
        check_read(8'h10, 32'hFFFF_FFFF, 32'h0000_1000, "R10 ch0 untouched");
        check_read(8'h20, 32'hFFFF_FFFF, 32'h800F_FFFC, "R10 ch1 untouched");

        // relock and try to clear channel 1
        reg_write(8'h00, 32'h0000_0000);
        check_read(8'h00, 32'hFFFF_FFFF, 32'h0, "R1 relock readback");
        reg_write(8'h20, 32'h0000_0000);
        check_read(8'h20, 32'hFFFF_FFFF, 32'h800F_FFFC, "R4 relocked ch1 kept");
        drive_fetch(1'b1, 32'h000F_FFFD, 1'b1, 1'b1, 3'd1, "R4 relocked ch1 still hits");

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule